// File: doc/BRIEF.md
# Stimulus Window Cropper with Phase-Split Decimation

This block takes a stream of multichannel EEG samples. Each beat carries one 16-bit signed fixed-point sample (8 integer bits, 8 fractional bits). Frames arrive interleaved, channel 0 first. A stimulus-start pulse opens an analysis window of four seconds. Only the leading one, two or three seconds of that window are stored, and the rest of the window is consumed and dropped.

The stored frames are then split by decimation phase. With a factor of `ds`, trial `p` holds frames `p`, `p+ds`, `p+2·ds` and so on. The frames that plain decimation would throw away are kept as extra trials, so one stimulus yields `ds` shortened trials. These trials leave on a valid/ready stream. Each beat is tagged with its phase, its frame index inside the trial and its channel. A last marker closes each trial. A channel mask restricts the output to a chosen electrode subset. The frame rate is the parameter `FPS`, which is 160 in a deployed system. The default is kept small so that the buffer stays compact.

Top module: `win_phase_splitter`

## Requirements
- R1: After reset, `out_valid`, `out_last` and `overlap` are 0 and `in_ready` is 1.
- R2: Input beats that arrive while no window is open are accepted and discarded, and no output is produced from them.
- R3: A `stim` pulse seen while idle opens a window. The first beat accepted after that cycle is channel 0 of frame 0. `cfg_sec`, `cfg_ds` and `cfg_mask` are sampled in that cycle. The kept length is `cfg_sec`·FPS frames, and a code of 0 is treated as 1.
- R4: Once the kept frames are stored, `in_ready` stays 0 until every trial has been emitted. The block then accepts and drops the rest of the 4·FPS-frame window and returns to idle.
- R5: Trials are emitted in phase order 0 to ds−1. Trial p carries the kept frames n with n mod ds = p, in rising n. `out_phase` is p and `out_frame` is (n−p)/ds. A `cfg_ds` code of 0 is treated as 1. When ds does not divide the kept length, the lower phases carry one frame more.
- R6: Inside a frame, only channels whose `cfg_mask` bit is 1 are emitted, in rising channel order, and `out_chan` gives the channel. A mask of all zeros is treated as all ones.
- R7: `out_last` is 1 exactly on the last emitted beat of each trial.
- R8: Sample values pass through unchanged.
- R9: While `out_valid` is 1 and `out_ready` is 0, the output beat and its tags hold steady.
- R10: A `stim` pulse that arrives while a window is in progress is ignored and sets `overlap`, which stays set until reset.
- R11: Changing `cfg_*` after the window has opened has no effect on that window's trials.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stim | input | 1 | Stimulus-start pulse |
| cfg_sec | input | 2 | Kept seconds, 1 to 3 |
| cfg_ds | input | 2 | Decimation factor, 1 to 3 |
| cfg_mask | input | CH | Channel enable mask |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted |
| in_data | input | DW | Input sample |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | DW | Output sample |
| out_phase | output | 2 | Trial phase index |
| out_frame | output | FW | Frame index within trial |
| out_chan | output | CW | Channel index |
| out_last | output | 1 | Last beat of trial |
| overlap | output | 1 | Sticky ignored-stimulus flag |

## Verification
The hardest case to reach is a factor-3 split of a kept length that 3 does not divide. There, phase 0 is one frame longer than the others, and a stall during emission must still let the window remainder be dropped exactly. This is driven with a one-second window at ds=3 while `out_ready` is toggled. A second trial follows straight after, so any slip in the count of dropped beats shows up as wrong frame numbers in the next trial. A mid-window stimulus that lands together with a data beat, and configuration changes made right after the window opens, cover the ignore cases.

// File: rtl/win_phase_splitter.sv
module win_phase_splitter #(
  parameter int CH  = 8,
  parameter int FPS = 16,
  parameter int DW  = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          stim,
  input  logic [1:0]                    cfg_sec,
  input  logic [1:0]                    cfg_ds,
  input  logic [CH-1:0]                 cfg_mask,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [DW-1:0]                 in_data,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [DW-1:0]                 out_data,
  output logic [1:0]                    out_phase,
  output logic [$clog2(4*FPS+4)-1:0]    out_frame,
  output logic [$clog2(CH)-1:0]         out_chan,
  output logic                          out_last,
  output logic                          overlap
);
  localparam int WIN   = 4 * FPS;
  localparam int FW    = $clog2(WIN + 4);
  localparam int CW    = $clog2(CH);
  localparam int DEPTH = 3 * FPS * CH;
  localparam int AW    = $clog2(DEPTH);

  typedef enum logic [1:0] {IDLE, CAP, EMIT, SKIP} st_t;
  st_t st;

  logic [DW-1:0] mem [DEPTH];
  logic [FW-1:0] wf, keep_q, rn, rk;
  logic [CW-1:0] wc, rc, hi;
  logic [AW-1:0] wa;
  logic [1:0]    ds_q, rp;
  logic [CH-1:0] mask_q;
  logic          acc, last_ch, end_ph, step;

  assign in_ready  = (st != EMIT);
  assign acc       = in_valid && in_ready;
  assign last_ch   = (rc == hi);
  assign end_ph    = ({1'b0, rn} + {{FW-1{1'b0}}, ds_q}) >= {1'b0, keep_q};
  assign out_valid = (st == EMIT) && mask_q[rc];
  assign out_data  = mem[AW'(rn * FW'(CH) + FW'(rc))];
  assign out_phase = rp;
  assign out_frame = rk;
  assign out_chan  = rc;
  assign out_last  = out_valid && last_ch && end_ph;
  assign step      = !mask_q[rc] || out_ready;

  always_comb begin
    hi = '0;
    for (int i = 0; i < CH; i++)
      if (mask_q[i]) hi = CW'(i);
  end

  always_ff @(posedge clk)
    if (st == CAP && acc) mem[wa] <= in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; wf <= '0; wc <= '0; wa <= '0; keep_q <= FW'(FPS);
      ds_q <= 2'd1; mask_q <= '1; rp <= '0; rn <= '0; rk <= '0; rc <= '0;
      overlap <= 1'b0;
    end else begin
      if (stim && st != IDLE) overlap <= 1'b1;
      case (st)
        IDLE: if (stim) begin
          st     <= CAP;
          wf     <= '0; wc <= '0; wa <= '0;
          keep_q <= (cfg_sec == 2'd3) ? FW'(3*FPS) : (cfg_sec == 2'd2) ? FW'(2*FPS) : FW'(FPS);
          ds_q   <= (cfg_ds == 2'd0) ? 2'd1 : cfg_ds;
          mask_q <= (cfg_mask == '0) ? '1 : cfg_mask;
        end
        CAP: if (acc) begin
          wa <= wa + 1'b1;
          if (wc == CW'(CH-1)) begin
            wc <= '0;
            wf <= wf + 1'b1;
            if (wf == keep_q - 1'b1) begin
              st <= EMIT; rp <= '0; rn <= '0; rk <= '0; rc <= '0;
            end
          end else wc <= wc + 1'b1;
        end
        EMIT: if (step) begin
          if (last_ch) begin
            rc <= '0;
            if (end_ph) begin
              if (rp == ds_q - 1'b1) st <= SKIP;
              else begin
                rp <= rp + 1'b1; rn <= FW'(rp) + 1'b1; rk <= '0;
              end
            end else begin
              rn <= rn + FW'(ds_q); rk <= rk + 1'b1;
            end
          end else rc <= rc + 1'b1;
        end
        SKIP: if (acc) begin
          if (wc == CW'(CH-1)) begin
            wc <= '0;
            wf <= wf + 1'b1;
            if (wf == FW'(WIN-1)) st <= IDLE;
          end else wc <= wc + 1'b1;
        end
        default: st <= IDLE;
      endcase
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_chan) && $stable(out_frame) && $stable(out_phase));
  assert_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
  assert_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_phase < ds_q);
  assert_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> mask_q[out_chan]);
  assert_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    overlap |=> overlap);
endmodule

// File: tb/test_win_phase_splitter.sv
module test_win_phase_splitter;
  localparam int CH = 8, FPS = 16, DW = 16, WIN = 4 * FPS;
  localparam int FW = $clog2(WIN + 4), CW = $clog2(CH);

  logic clk = 0, rst_n = 0, stim = 0, in_valid = 0, out_ready = 1;
  logic [1:0] cfg_sec = 1, cfg_ds = 1;
  logic [CH-1:0] cfg_mask = '1;
  logic [DW-1:0] in_data = '0;
  logic in_ready, out_valid, out_last, overlap;
  logic [DW-1:0] out_data;
  logic [1:0] out_phase;
  logic [FW-1:0] out_frame;
  logic [CW-1:0] out_chan;
  int nchk = 0, nfail = 0, cyc = 0;

  win_phase_splitter #(.CH(CH), .FPS(FPS), .DW(DW)) i_win_phase_splitter (
    .clk(clk), .rst_n(rst_n), .stim(stim), .cfg_sec(cfg_sec), .cfg_ds(cfg_ds),
    .cfg_mask(cfg_mask), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_phase(out_phase), .out_frame(out_frame), .out_chan(out_chan),
    .out_last(out_last), .overlap(overlap));

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic send_beat(logic [DW-1:0] d, bit s);
    bit ok;
    in_valid = 1; in_data = d; stim = s;
    forever begin
      #3 ok = in_ready;
      @(negedge clk);
      stim = 0;
      if (ok) break;
    end
  endtask

  task automatic drive(int tid, int pre, int ovl_at, bit chg);
    @(negedge clk);
    for (int i = 0; i < pre; i++) send_beat(DW'(16'hFFFF ^ i), 0);
    in_valid = 0; stim = 1;
    @(negedge clk);
    stim = 0;
    if (chg) begin cfg_sec = 3; cfg_ds = 2; cfg_mask = 8'hF0; end
    for (int f = 0; f < WIN; f++)
      for (int c = 0; c < CH; c++)
        send_beat(DW'((tid << 10) | (f << 3) | c), (f * CH + c) == ovl_at);
    in_valid = 0;
  endtask

  task automatic collect(int tid, int se, int de, logic [CH-1:0] me, bit stall);
    int k_len = se * FPS, hi = 0;
    for (int c = 0; c < CH; c++) if (me[c]) hi = c;
    for (int p = 0; p < de; p++)
      for (int n = p; n < k_len; n += de)
        for (int c = 0; c < CH; c++) begin
          if (me[c]) begin
            bit pend = 0;
            logic [DW-1:0] sd = '0;
            logic [CW-1:0] sc = '0;
            forever begin
              @(negedge clk);
              out_ready = stall ? (cyc % 3 != 0) : 1'b1;
              #3;
              if (pend) begin
                chk(out_valid && out_data == sd && out_chan == sc, "R9", "held beat", int'(out_data), int'(sd));
                pend = 0;
              end
              if (out_valid && !out_ready) begin pend = 1; sd = out_data; sc = out_chan; end
              if (out_valid && out_ready) break;
            end
            chk(!in_ready, "R4", "in_ready during emit", int'(in_ready), 0);
            chk(out_data == DW'((tid << 10) | (n << 3) | c), "R8", "data", int'(out_data), (tid << 10) | (n << 3) | c);
            chk(out_phase == 2'(p), "R5", "phase", int'(out_phase), p);
            chk(out_frame == FW'((n - p) / de), "R5", "frame", int'(out_frame), (n - p) / de);
            chk(out_chan == CW'(c), "R6", "channel", int'(out_chan), c);
            chk(out_last == (c == hi && n + de >= k_len), "R7", "last", int'(out_last), int'(c == hi && n + de >= k_len));
          end
        end
    out_ready = 1;
  endtask

  task automatic run(int tid, logic [1:0] sec, logic [1:0] ds, logic [CH-1:0] mask,
                     int pre, bit stall, int ovl_at, bit chg);
    int se = (sec == 0) ? 1 : sec;
    int de = (ds == 0) ? 1 : ds;
    logic [CH-1:0] me = (mask == 0) ? '1 : mask;
    cfg_sec = sec; cfg_ds = ds; cfg_mask = mask;
    fork
      drive(tid, pre, ovl_at, chg);
      collect(tid, se, de, me, stall);
    join
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); #3;
      chk(!out_valid && in_ready, "R2", "idle after window", int'(out_valid), 0);
    end
  endtask

  task automatic t_reset;
    #1;
    chk(!out_valid && !out_last && !overlap && in_ready, "R1", "reset outputs",
        {out_valid, out_last, overlap, in_ready}, 1);
  endtask

  task automatic t_basic;      run(1, 1, 1, 8'hFF, 10, 0, -1, 0); endtask   // R3 R2
  task automatic t_split2;     run(2, 2, 2, 8'h5A, 3, 1, -1, 0); endtask    // R5 R6 R9
  task automatic t_uneven3;    run(3, 1, 3, 8'h81, 0, 1, -1, 0);            // R5 uneven phases, R4 skip count
                               run(4, 3, 3, 8'h24, 0, 0, -1, 0); endtask    // next trial proves alignment
  task automatic t_codes;      run(5, 0, 0, 8'h00, 2, 0, -1, 0); endtask    // R3 R5 R6 zero codes
  task automatic t_cfgchange;  run(6, 1, 1, 8'h0F, 1, 0, -1, 1); endtask    // R11
  task automatic t_overlap;
    @(negedge clk); #3;
    chk(!overlap, "R10", "flag clear before overlap", int'(overlap), 0);
    run(7, 1, 2, 8'h3C, 0, 0, 37, 0);
    @(negedge clk); #3;
    chk(overlap, "R10", "flag set after stim in window", int'(overlap), 1);
    repeat (5) @(negedge clk);
    #3 chk(overlap, "R10", "flag sticky", int'(overlap), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_basic();
    t_split2();
    t_uneven3();
    t_codes();
    t_cfgchange();
    t_overlap();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule